// File: doc/BRIEF.md
# Host Register Port with Windowed Memory Access

This block is the register port a host processor sees on a peripheral. The host drives a 4-bit register address, a select, and a read or a write strobe. It then waits for the port to pull an active-low acknowledge. A handful of directly addressed registers hold the interrupt enable and flag pair, two operating-mode words and two clock-configuration words. A write of a fixed key to a boot register returns all of them to their defaults.

An internal RAM is not mapped into the 16-entry space. The host reaches it through a pointer register and a data window instead. Every access to the window moves the pointer on by one unit of the selected indirect width: 4 bytes for 32-bit accesses, 2 bytes for 16-bit accesses. In the 16-bit indirect mode a separate stage register holds the upper half of the pointer, and a narrow write to the pointer register sets only the lower half. Half-words are packed big-endian inside each RAM word, and reads hand them back in the order they were written. The host data bus may be used 32 or 16 bits wide. In the narrow case only the low half carries data.

Top module: `hostreg_window`

## Requirements
- R1: After reset the registers read as follows: 0x5 reads 0x0000, 0x6 reads 0x000F, 0x8 reads 0x0005, 0x9 reads 0x0009, 0xE reads 0x0008 and 0xF reads 0x0006. The stage (0xA), pointer (0xB) and window (0xC) registers read 0 until each has been written. `reg_ack_n` is high and `reg_rdata` is 0.
- R2: An access begins at the first rising edge at which `reg_sel` is high together with `reg_rd` or `reg_wr`. `reg_ack_n` goes low 2 clock edges after that sampling edge. It stays low while the strobe is held, and it returns high 2 edges after the strobe is dropped. Each strobe performs exactly one access, and read data stays stable while acknowledge is low.
- R3: Writes to 0x5, 0x8, 0x9, 0xE and 0xF store the low 16 bits, which later reads return. Writes to the flag register 0x6 and to the unmapped addresses 0x0 to 0x4 and 0x7 have no effect, and unmapped addresses read 0.
- R4: Bit 1 of the bus-mode register (0x8) selects the host bus width: 1 means 32 bits (the value 0x000A) and 0 means 16 bits (0x0015 or the default 0x0005). In 16-bit mode `reg_wdata[31:16]` is ignored and `reg_rdata[31:16]` reads 0.
- R5: Bit 1 of the memory-mode register (0x9) selects the indirect width: 1 means 32-bit (0x000A) and 0 means 16-bit (0x0005 or the default 0x0009). Every read or write of 0xC advances the pointer by 4 in 32-bit mode and by 2 in 16-bit mode. A 32-bit window access transfers a whole RAM word.
- R6: In 16-bit indirect mode the stage register 0xA holds pointer bits [31:16] and a write to 0xB sets only bits [15:0]. A pointer increment that carries out of bit 15 also carries into the stage value.
- R7: In 16-bit indirect mode, a half-word written where pointer bit 1 is 0 is stored in RAM word bits [31:16]. A half-word written where pointer bit 1 is 1 is stored in bits [15:0]. This makes 0x1234 followed by 0x5678 read back as the word 0x12345678 in 32-bit mode.
- R8: In 16-bit indirect mode, successive window reads return half-words in the order they were written. The first read after the pointer is loaded returns the half-word at exactly that address.
- R9: Writing 0x008A to address 0xD returns every direct register and the pointer to its reset state, including the "not yet written" state of 0xA to 0xC. Writing any other value to 0xD has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Direct register address |
| reg_sel | input | 1 | Port select, active high |
| reg_rd | input | 1 | Read strobe, active high |
| reg_wr | input | 1 | Write strobe, active high |
| reg_wdata | input | 32 | Write data from the host |
| reg_rdata | output | 32 | Read data, valid while acknowledge is low |
| reg_ack_n | output | 1 | Access acknowledge, active low |

## Verification
Most faults in the pointer logic show up at the ports only at the next read of the window or of 0xB, one full handshake later. The bench therefore reads the pointer back after every burst and checks the half-word order on the first read after a reload. A stuck mode bit shows up as a wrong step or as nonzero upper read bits on the very next window access. A handshake fault shows up as an acknowledge latency other than two edges, which is visible on the first access after reset. A faulty reboot leaves a mode register off its default, which a single read reveals.

// File: rtl/hrw_pkg.sv
package hrw_pkg;
  localparam int HOST_W = 32;
  localparam int HALF_W = 16;
  localparam int WIDTH_BIT = 1;

  localparam logic [3:0] A_IRQ_EN   = 4'h5;
  localparam logic [3:0] A_IRQ_FLG  = 4'h6;
  localparam logic [3:0] A_BUS_MODE = 4'h8;
  localparam logic [3:0] A_MEM_MODE = 4'h9;
  localparam logic [3:0] A_STAGE    = 4'hA;
  localparam logic [3:0] A_PTR      = 4'hB;
  localparam logic [3:0] A_WINDOW   = 4'hC;
  localparam logic [3:0] A_BOOT     = 4'hD;
  localparam logic [3:0] A_CLK_HI   = 4'hE;
  localparam logic [3:0] A_CLK_LO   = 4'hF;

  localparam logic [HALF_W-1:0] D_IRQ_EN   = 16'h0000;
  localparam logic [HALF_W-1:0] D_IRQ_FLG  = 16'h000F;
  localparam logic [HALF_W-1:0] D_BUS_MODE = 16'h0005;
  localparam logic [HALF_W-1:0] D_MEM_MODE = 16'h0009;
  localparam logic [HALF_W-1:0] D_CLK_HI   = 16'h0008;
  localparam logic [HALF_W-1:0] D_CLK_LO   = 16'h0006;
  localparam logic [HALF_W-1:0] BOOT_KEY   = 16'h008A;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_EXEC = 2'd1,
    HS_HOLD = 2'd2
  } hs_state_t;
endpackage

// File: rtl/hrw_handshake.sv
module hrw_handshake
  import hrw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic go,
  output logic ack_n
);
  hs_state_t st;
  logic      req_s;

  // one sampling flop on the asynchronous request, then a fixed two-edge answer
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= HS_IDLE;
      req_s <= 1'b0;
      ack_n <= 1'b1;
    end else begin
      req_s <= req;
      case (st)
        HS_IDLE: if (req_s) st <= HS_EXEC;
        HS_EXEC: begin
          st    <= HS_HOLD;
          ack_n <= 1'b0;
        end
        HS_HOLD: if (!req_s) begin
          st    <= HS_IDLE;
          ack_n <= 1'b1;
        end
        default: st <= HS_IDLE;
      endcase
    end
  end

  assign go = (st == HS_IDLE) && req_s;
endmodule

// File: rtl/hrw_ram.sv
module hrw_ram #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 16
) (
  input  logic                clk,
  input  logic [LANES-1:0]    we,
  input  logic [AW-1:0]       idx,
  input  logic [LANES*LW-1:0] wd,
  output logic [LANES*LW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  // one array per lane so each lane maps onto a plain block RAM
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[l]) mem[idx] <= wd[l*LW +: LW];
      q[l*LW +: LW] <= mem[idx];
    end
  end
endmodule

// File: rtl/hrw_regfile.sv
module hrw_regfile
  import hrw_pkg::*;
#(
  parameter int RAM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              is_wr,
  input  logic [3:0]        addr,
  input  logic [HOST_W-1:0] wdata,
  input  logic [HOST_W-1:0] ram_q,
  output logic [1:0]        ram_we,
  output logic [RAM_AW-1:0] ram_idx,
  output logic [HOST_W-1:0] ram_wd,
  output logic [HOST_W-1:0] rdata,
  output logic              bus32,
  output logic              ind32,
  output logic [HOST_W-1:0] ptr
);
  localparam logic [HOST_W-1:0] STEP_WIDE   = HOST_W'(4);
  localparam logic [HOST_W-1:0] STEP_NARROW = HOST_W'(2);
  localparam logic [HALF_W-1:0] ZH          = '0;

  logic [HALF_W-1:0] irq_en, bus_mode, mem_mode, clk_hi, clk_lo;
  logic              stage_seen, ptr_seen, data_seen;
  logic              win_hit, reboot;
  logic [HOST_W-1:0] step, win_rd, rd_val, rd_mask;

  assign bus32   = bus_mode[WIDTH_BIT];
  assign ind32   = mem_mode[WIDTH_BIT];
  assign step    = ind32 ? STEP_WIDE : STEP_NARROW;
  assign win_hit = go && (addr == A_WINDOW);
  assign reboot  = go && is_wr && (addr == A_BOOT) && (wdata[HALF_W-1:0] == BOOT_KEY);

  // RAM side: word index from the pointer, half lane chosen by pointer bit 1
  assign ram_idx   = ptr[RAM_AW+1:2];
  assign ram_wd    = ind32 ? wdata : {wdata[HALF_W-1:0], wdata[HALF_W-1:0]};
  assign ram_we[1] = win_hit && is_wr && (ind32 || !ptr[1]);
  assign ram_we[0] = win_hit && is_wr && (ind32 || ptr[1]);

  always_comb begin
    if (ind32)       win_rd = ram_q;
    else if (ptr[1]) win_rd = {ZH, ram_q[HALF_W-1:0]};
    else             win_rd = {ZH, ram_q[HOST_W-1:HALF_W]};
  end

  always_comb begin
    case (addr)
      A_IRQ_EN:   rd_val = {ZH, irq_en};
      A_IRQ_FLG:  rd_val = {ZH, D_IRQ_FLG};
      A_BUS_MODE: rd_val = {ZH, bus_mode};
      A_MEM_MODE: rd_val = {ZH, mem_mode};
      A_STAGE:    rd_val = stage_seen ? {ZH, ptr[HOST_W-1:HALF_W]} : '0;
      A_PTR:      rd_val = !ptr_seen ? '0 : (ind32 ? ptr : {ZH, ptr[HALF_W-1:0]});
      A_WINDOW:   rd_val = data_seen ? win_rd : '0;
      A_CLK_HI:   rd_val = {ZH, clk_hi};
      A_CLK_LO:   rd_val = {ZH, clk_lo};
      default:    rd_val = '0;
    endcase
  end

  assign rd_mask = bus32 ? '1 : {ZH, {HALF_W{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst || reboot) begin
      irq_en     <= D_IRQ_EN;
      bus_mode   <= D_BUS_MODE;
      mem_mode   <= D_MEM_MODE;
      clk_hi     <= D_CLK_HI;
      clk_lo     <= D_CLK_LO;
      stage_seen <= 1'b0;
      ptr_seen   <= 1'b0;
      data_seen  <= 1'b0;
      ptr        <= '0;
      rdata      <= '0;
    end else if (go) begin
      if (is_wr) begin
        rdata <= '0;
        case (addr)
          A_IRQ_EN:   irq_en   <= wdata[HALF_W-1:0];
          A_BUS_MODE: bus_mode <= wdata[HALF_W-1:0];
          A_MEM_MODE: mem_mode <= wdata[HALF_W-1:0];
          A_CLK_HI:   clk_hi   <= wdata[HALF_W-1:0];
          A_CLK_LO:   clk_lo   <= wdata[HALF_W-1:0];
          A_STAGE: begin
            ptr[HOST_W-1:HALF_W] <= wdata[HALF_W-1:0];
            stage_seen           <= 1'b1;
          end
          A_PTR: begin
            if (ind32) ptr <= wdata;
            else       ptr[HALF_W-1:0] <= wdata[HALF_W-1:0];
            ptr_seen <= 1'b1;
          end
          A_WINDOW: begin
            data_seen <= 1'b1;
            ptr       <= ptr + step;
          end
          default: ;
        endcase
      end else begin
        rdata <= rd_val & rd_mask;
        if (addr == A_WINDOW) ptr <= ptr + step;
      end
    end
  end
endmodule

// File: rtl/hostreg_window.sv
module hostreg_window
  import hrw_pkg::*;
#(
  parameter int RAM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        reg_addr,
  input  logic              reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [HOST_W-1:0] reg_wdata,
  output logic [HOST_W-1:0] reg_rdata,
  output logic              reg_ack_n
);
  logic              go, bus32, ind32;
  logic [HOST_W-1:0] wd_eff, ptr, ram_wd, ram_q;
  logic [1:0]        ram_we;
  logic [RAM_AW-1:0] ram_idx;

  // a narrow host bus carries nothing on its upper half
  assign wd_eff = bus32 ? reg_wdata : {{HALF_W{1'b0}}, reg_wdata[HALF_W-1:0]};

  hrw_handshake u_hs (
    .clk   (clk),
    .rst   (rst),
    .req   (reg_sel && (reg_rd || reg_wr)),
    .go    (go),
    .ack_n (reg_ack_n)
  );

  hrw_regfile #(.RAM_AW(RAM_AW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .is_wr   (reg_wr),
    .addr    (reg_addr),
    .wdata   (wd_eff),
    .ram_q   (ram_q),
    .ram_we  (ram_we),
    .ram_idx (ram_idx),
    .ram_wd  (ram_wd),
    .rdata   (reg_rdata),
    .bus32   (bus32),
    .ind32   (ind32),
    .ptr     (ptr)
  );

  hrw_ram #(.AW(RAM_AW), .LANES(2), .LW(HALF_W)) u_ram (
    .clk (clk),
    .we  (ram_we),
    .idx (ram_idx),
    .wd  (ram_wd),
    .q   (ram_q)
  );
endmodule

// File: rtl/hostreg_window_chk.sv
module hostreg_window_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  addr,
  input logic        sel,
  input logic        rd,
  input logic        wr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        ack_n,
  input logic        go,
  input logic        bus32,
  input logic        ind32,
  input logic [31:0] ptr
);
  logic req;
  assign req = sel && (rd || wr);

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!bus32 && !ind32 && ack_n)); // R1

  AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> ($past(req, 2) && $past(req))); // R2

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && req && $past(req)) |=> !ack_n); // R2

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_n) |-> !$past(req)); // R2

  AST_SINGLE_GO: assert property (@(posedge clk) disable iff (rst)
    go |=> !go); // R2

  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && $past(!ack_n)) |-> $stable(rdata)); // R2

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && !bus32) |-> (rdata[31:16] == 16'h0)); // R4

  AST_WINDOW_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(go && (addr == 4'hC)) |-> (ptr == $past(ptr) + ($past(ind32) ? 32'd4 : 32'd2))); // R5

  AST_BOOT_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    $past(go && wr && (addr == 4'hD) && (wdata[15:0] == 16'h008A)) |-> (!bus32 && !ind32 && (ptr == 32'h0))); // R9
endmodule

bind hostreg_window hostreg_window_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .addr  (reg_addr),
  .sel   (reg_sel),
  .rd    (reg_rd),
  .wr    (reg_wr),
  .wdata (reg_wdata),
  .rdata (reg_rdata),
  .ack_n (reg_ack_n),
  .go    (go),
  .bus32 (bus32),
  .ind32 (ind32),
  .ptr   (ptr)
);

// File: tb/tb_hostreg_window.sv
module tb_hostreg_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_ack_n;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  hostreg_window dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_sel(reg_sel),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack_n(reg_ack_n)
  );

  // {write, tag, address, data or expected read value}
  localparam int NV = 57;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 4'd5, 4'h8, 32'h0000000A}, {1'b1, 4'd5, 4'h9, 32'h0000000A},
    {1'b1, 4'd5, 4'hB, 32'h001B0000}, {1'b1, 4'd5, 4'hC, 32'h12345678},
    {1'b1, 4'd5, 4'hC, 32'h9ABCDEF0}, {1'b1, 4'd5, 4'hC, 32'h0F0F0F0F},
    {1'b1, 4'd5, 4'hC, 32'hF0F0F0F0}, {1'b1, 4'd5, 4'hB, 32'h001B0000},
    {1'b0, 4'd5, 4'hC, 32'h12345678}, {1'b0, 4'd5, 4'hC, 32'h9ABCDEF0},
    {1'b0, 4'd5, 4'hC, 32'h0F0F0F0F}, {1'b0, 4'd5, 4'hC, 32'hF0F0F0F0},
    {1'b0, 4'd5, 4'hB, 32'h001B0010},
    {1'b1, 4'd6, 4'h8, 32'h00000015}, {1'b1, 4'd6, 4'h9, 32'h00000005},
    {1'b1, 4'd6, 4'hA, 32'h0000001B}, {1'b1, 4'd6, 4'hB, 32'h00000020},
    {1'b1, 4'd8, 4'hC, 32'h00001234}, {1'b1, 4'd8, 4'hC, 32'h00005678},
    {1'b1, 4'd8, 4'hC, 32'h00009ABC}, {1'b1, 4'd8, 4'hC, 32'h0000DEF0},
    {1'b1, 4'd8, 4'hC, 32'h00000F0F}, {1'b1, 4'd8, 4'hC, 32'h00000F0F},
    {1'b1, 4'd8, 4'hC, 32'h0000F0F0}, {1'b1, 4'd8, 4'hC, 32'h0000F0F0},
    {1'b1, 4'd6, 4'hA, 32'h0000001B}, {1'b1, 4'd6, 4'hB, 32'h00000020},
    {1'b0, 4'd8, 4'hC, 32'h00001234}, {1'b0, 4'd8, 4'hC, 32'h00005678},
    {1'b0, 4'd8, 4'hC, 32'h00009ABC}, {1'b0, 4'd8, 4'hC, 32'h0000DEF0},
    {1'b0, 4'd8, 4'hC, 32'h00000F0F}, {1'b0, 4'd8, 4'hC, 32'h00000F0F},
    {1'b0, 4'd8, 4'hC, 32'h0000F0F0}, {1'b0, 4'd8, 4'hC, 32'h0000F0F0},
    {1'b0, 4'd5, 4'hB, 32'h00000030}, {1'b0, 4'd6, 4'hA, 32'h0000001B},
    {1'b1, 4'd7, 4'h8, 32'h0000000A}, {1'b1, 4'd7, 4'h9, 32'h0000000A},
    {1'b1, 4'd7, 4'hB, 32'h001B0020},
    {1'b0, 4'd7, 4'hC, 32'h12345678}, {1'b0, 4'd7, 4'hC, 32'h9ABCDEF0},
    {1'b0, 4'd7, 4'hC, 32'h0F0F0F0F}, {1'b0, 4'd7, 4'hC, 32'hF0F0F0F0},
    {1'b1, 4'd8, 4'h8, 32'h00000015}, {1'b1, 4'd8, 4'h9, 32'h00000005},
    {1'b1, 4'd8, 4'hA, 32'h0000001B}, {1'b1, 4'd8, 4'hB, 32'h00000022},
    {1'b0, 4'd8, 4'hC, 32'h00005678}, {1'b0, 4'd8, 4'hC, 32'h00009ABC},
    {1'b1, 4'd6, 4'hA, 32'h00000000}, {1'b1, 4'd6, 4'hB, 32'h0000FFFE},
    {1'b1, 4'd6, 4'hC, 32'h0000AAAA},
    {1'b0, 4'd6, 4'hA, 32'h00000001}, {1'b0, 4'd6, 4'hB, 32'h00000000},
    {1'b1, 4'd4, 4'h5, 32'hFFFF1234}, {1'b0, 4'd4, 4'h5, 32'h00001234}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one host access; returns read data, edges to acknowledge and edges to release
  task automatic access(input logic w, input logic [3:0] a, input logic [31:0] d,
                        output logic [31:0] q, output int lat, output int rel);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_sel = 1'b1; reg_rd = !w; reg_wr = w;
    lat = 0;
    while (reg_ack_n && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    q = reg_rdata;
    reg_sel = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
    rel = 0;
    while (!reg_ack_n && rel < 40) begin
      @(negedge clk);
      rel++;
    end
    if (lat >= 40 || rel >= 40) check("R2 handshake timeout", 32'(lat), 32'd3);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] q;
    int lat, rel;
    access(1'b1, a, d, q, lat, rel);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] q;
    int lat, rel;
    access(1'b0, a, 32'h0, q, lat, rel);
    check(tag, q, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL R2 watchdog expired got=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] q;
    int lat, rel;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 ack idle", {31'h0, reg_ack_n}, 32'h1);
    check("R1 rdata idle", reg_rdata, 32'h0);

    // R2: latency and release timing on the first access
    access(1'b0, 4'h6, 32'h0, q, lat, rel);
    check("R2 ack latency", 32'(lat), 32'd3);
    check("R2 ack release", 32'(rel), 32'd2);
    check("R1 flag default", q, 32'h0000000F);

    rd_chk("R1 irq enable default", 4'h5, 32'h0);
    rd_chk("R1 bus mode default", 4'h8, 32'h5);
    rd_chk("R1 mem mode default", 4'h9, 32'h9);
    rd_chk("R1 clk hi default", 4'hE, 32'h8);
    rd_chk("R1 clk lo default", 4'hF, 32'h6);
    rd_chk("R1 stage unwritten", 4'hA, 32'h0);
    rd_chk("R1 pointer unwritten", 4'hB, 32'h0);
    rd_chk("R1 window unwritten", 4'hC, 32'h0);

    // table-driven window traffic in both widths
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wr(VEC[i][35:32], VEC[i][31:0]);
      else            rd_chk(tag_name(VEC[i][39:36]), VEC[i][35:32], VEC[i][31:0]);
    end

    // R3: writable, read-only and unmapped locations
    wr(4'h6, 32'h00001234);
    rd_chk("R3 flag read-only", 4'h6, 32'h0000000F);
    wr(4'h3, 32'h0000FFFF);
    rd_chk("R3 unmapped 0x3", 4'h3, 32'h0);
    wr(4'h7, 32'h0000FFFF);
    rd_chk("R3 unmapped 0x7", 4'h7, 32'h0);
    wr(4'hE, 32'h00000011);
    rd_chk("R3 clk hi write", 4'hE, 32'h11);
    wr(4'hF, 32'h00000022);
    rd_chk("R3 clk lo write", 4'hF, 32'h22);

    // R9: a wrong key does nothing, the right key restores defaults
    wr(4'hD, 32'h00000001);
    rd_chk("R9 wrong key ignored", 4'h8, 32'h15);
    wr(4'hD, 32'h0000008A);
    rd_chk("R9 bus mode restored", 4'h8, 32'h5);
    rd_chk("R9 mem mode restored", 4'h9, 32'h9);
    rd_chk("R9 clk hi restored", 4'hE, 32'h8);
    rd_chk("R9 clk lo restored", 4'hF, 32'h6);
    rd_chk("R9 irq enable restored", 4'h5, 32'h0);
    rd_chk("R9 stage cleared", 4'hA, 32'h0);
    rd_chk("R9 pointer cleared", 4'hB, 32'h0);
    rd_chk("R9 window cleared", 4'hC, 32'h0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule